// File: doc/BRIEF.md
# Scanline Sprite Selector

This block prepares the sprite list for one display line. A 256-byte attribute memory holds 64 sprite records of four bytes each: vertical position, tile number, attribute byte and horizontal position. When a start pulse arrives, the block latches the target line and the height mode. It then fills a 32-byte secondary buffer with 0xFF, one byte per clock. After that it walks the records from index 0 upward. Each record whose vertical extent covers the line is copied, all four bytes, into the next free slot of the buffer. The line renderer reads that buffer afterwards.

There are at most eight slots. The lowest-indexed eight matching sprites win. A further match raises a sticky overflow flag, which only an external frame-start pulse clears.

The controller has five named states:

- `ST_IDLE` waits for start and moves to `ST_CLEAR`.
- `ST_CLEAR` writes the filler byte. After the last buffer byte it moves to `ST_SCAN`.
- `ST_SCAN` reads the vertical byte of the current record. On a match with a free slot it writes that byte and moves to `ST_COPY`. Otherwise it advances to the next record, or moves to `ST_DONE` after record 63.
- `ST_COPY` writes the remaining three bytes. It then returns to `ST_SCAN`, or moves to `ST_DONE` after the last record.
- `ST_DONE` holds the done flag and moves to `ST_CLEAR` on a new start.

Top module: `sprite_line_eval`

## Requirements
- R1: A start pulse seen while idle or done begins a new evaluation, and done reads 0 from the next cycle.
- R2: An evaluation first writes 0xFF to secondary addresses 0 to 31 in ascending order, one byte per clock.
- R3: A sprite matches when (line − Y) mod 256 is below the height. Records are examined in ascending index order, so the lowest-indexed matches take the slots.
- R4: With tall = 0 the height is 8 rows; with tall = 1 it is 16 rows (a difference of 8 matches only in tall mode, and 16 never matches).
- R5: A matching sprite with a free slot s is copied to secondary addresses 4s+0..4s+3 as Y, tile, attribute, X, in that order. At most 8 slots are used.
- R6: The overflow output rises when a matching sprite is found while all 8 slots are taken, and it stays high until cleared. Exactly 8 matches leave it low.
- R7: A frame_start pulse clears overflow; if it falls in the same cycle as a new overflow event, the flag is set.
- R8: Done rises after all 64 records are examined and stays high with no buffer writes until the next start. A start pulse during an evaluation is ignored.
- R9: The attribute byte, which carries the palette choice (colour 0 meaning transparent), priority and flip bits, is copied unchanged.
- R10: After reset, done, overflow and the buffer write enable are all 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin evaluation pulse |
| frame_start | input | 1 | Clears the overflow flag |
| line | input | 8 | Target scanline |
| tall | input | 1 | Height mode: 0 = 8 rows, 1 = 16 rows |
| oam_addr | output | 8 | Attribute memory byte address |
| oam_data | input | 8 | Attribute memory read data (same cycle) |
| sec_we | output | 1 | Secondary buffer write enable |
| sec_addr | output | 5 | Secondary buffer byte address |
| sec_wdata | output | 8 | Secondary buffer write data |
| done | output | 1 | Evaluation complete |
| overflow | output | 1 | Sticky sprite overflow flag |

## Verification
The clearing pulse on frame_start and the setting of overflow by a ninth match can land in the same cycle. The bench places matching sprites at records 0 to 8. It counts 32 clear cycles and four cycles per copied sprite, which puts the ninth test in cycle 65 after the start edge, and pulses frame_start in exactly that cycle. The flag must read 1 afterwards. A later frame_start in the done state must read 0.

// File: rtl/spr_eval_pkg.sv
package spr_eval_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_CLEAR,
        ST_SCAN,
        ST_COPY,
        ST_DONE
    } eval_st_t;
endpackage

// File: rtl/spr_range_check.sv
module spr_range_check #(
    parameter int SHORT_H = 8,
    parameter int TALL_H  = 16
) (
    input  logic [7:0] line,
    input  logic [7:0] ypos,
    input  logic       tall,
    output logic       hit
);
    localparam logic [7:0] H_SHORT = 8'(SHORT_H);
    localparam logic [7:0] H_TALL  = 8'(TALL_H);

    logic [7:0] delta;

    always_comb begin
        delta = line - ypos;
        hit   = delta < (tall ? H_TALL : H_SHORT);
    end
endmodule

// File: rtl/spr_slot_ctr.sv
module spr_slot_ctr #(
    parameter int SLOTS = 8,
    parameter int CNT_W = $clog2(SLOTS + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             clr,
    input  logic             inc,
    output logic [CNT_W-1:0] count,
    output logic             full
);
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n)
            count <= '0;
        else if (clr)
            count <= '0;
        else if (inc)
            count <= count + 1'b1;
    end

    assign full = (count == CNT_W'(SLOTS));
endmodule

// File: rtl/sprite_line_eval.sv
module sprite_line_eval #(
    parameter int NUM_SPR = 64,
    parameter int SLOTS   = 8,
    parameter int SHORT_H = 8,
    parameter int TALL_H  = 16
) (
    input  logic                                      clk,
    input  logic                                      rst_n,
    input  logic                                      start,
    input  logic                                      frame_start,
    input  logic [7:0]                                line,
    input  logic                                      tall,
    output logic [$clog2(NUM_SPR*4)-1:0]              oam_addr,
    input  logic [7:0]                                oam_data,
    output logic                                      sec_we,
    output logic [$clog2(SLOTS*4)-1:0]                sec_addr,
    output logic [7:0]                                sec_wdata,
    output logic                                      done,
    output logic                                      overflow
);
    import spr_eval_pkg::*;

    localparam int ENT_BYTES = 4;
    localparam int IDX_W     = $clog2(NUM_SPR);
    localparam int SLOT_W    = $clog2(SLOTS);
    localparam int SEC_AW    = $clog2(SLOTS * ENT_BYTES);
    localparam int CNT_W     = $clog2(SLOTS + 1);
    localparam logic [IDX_W-1:0]  LAST_IDX = IDX_W'(NUM_SPR - 1);
    localparam logic [SEC_AW-1:0] LAST_SEC = SEC_AW'(SLOTS * ENT_BYTES - 1);

    eval_st_t          state, state_n;
    logic [IDX_W-1:0]  idx;
    logic [1:0]        sub;
    logic [SEC_AW-1:0] clr_cnt;
    logic [7:0]        line_q;
    logic              tall_q;
    logic              hit;
    logic              slot_clr, slot_inc, slot_full;
    logic [CNT_W-1:0]  slot_cnt;
    logic              accept, set_ovf, take;

    spr_range_check #(.SHORT_H(SHORT_H), .TALL_H(TALL_H)) u_range (
        .line (line_q),
        .ypos (oam_data),
        .tall (tall_q),
        .hit  (hit)
    );

    spr_slot_ctr #(.SLOTS(SLOTS), .CNT_W(CNT_W)) u_slots (
        .clk   (clk),
        .rst_n (rst_n),
        .clr   (slot_clr),
        .inc   (slot_inc),
        .count (slot_cnt),
        .full  (slot_full)
    );

    // Next state and outputs
    always_comb begin
        state_n   = state;
        oam_addr  = {idx, 2'b00};
        sec_we    = 1'b0;
        sec_addr  = clr_cnt;
        sec_wdata = 8'hFF;
        done      = 1'b0;
        accept    = 1'b0;
        set_ovf   = 1'b0;
        take      = 1'b0;
        slot_inc  = 1'b0;
        unique case (state)
            ST_IDLE: begin
                if (start) begin
                    accept  = 1'b1;
                    state_n = ST_CLEAR;
                end
            end
            ST_CLEAR: begin
                sec_we = 1'b1;
                if (clr_cnt == LAST_SEC)
                    state_n = ST_SCAN;
            end
            ST_SCAN: begin
                take    = hit && !slot_full;
                set_ovf = hit && slot_full;
                if (take) begin
                    sec_we    = 1'b1;
                    sec_addr  = {slot_cnt[SLOT_W-1:0], 2'b00};
                    sec_wdata = oam_data;
                    state_n   = ST_COPY;
                end else if (idx == LAST_IDX) begin
                    state_n = ST_DONE;
                end
            end
            ST_COPY: begin
                oam_addr  = {idx, sub};
                sec_we    = 1'b1;
                sec_addr  = {slot_cnt[SLOT_W-1:0], sub};
                sec_wdata = oam_data;
                if (sub == 2'd3) begin
                    slot_inc = 1'b1;
                    state_n  = (idx == LAST_IDX) ? ST_DONE : ST_SCAN;
                end
            end
            ST_DONE: begin
                done = 1'b1;
                if (start) begin
                    accept  = 1'b1;
                    state_n = ST_CLEAR;
                end
            end
            default: state_n = ST_IDLE;
        endcase
    end

    assign slot_clr = accept;

    // State register and datapath
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state    <= ST_IDLE;
            idx      <= '0;
            sub      <= '0;
            clr_cnt  <= '0;
            line_q   <= '0;
            tall_q   <= 1'b0;
            overflow <= 1'b0;
        end else begin
            state <= state_n;
            if (set_ovf)
                overflow <= 1'b1;
            else if (frame_start)
                overflow <= 1'b0;
            if (accept) begin
                line_q  <= line;
                tall_q  <= tall;
                clr_cnt <= '0;
                idx     <= '0;
                sub     <= '0;
            end else begin
                if (state == ST_CLEAR)
                    clr_cnt <= clr_cnt + 1'b1;
                if (state == ST_SCAN) begin
                    if (take)
                        sub <= 2'd1;
                    else
                        idx <= idx + 1'b1;
                end
                if (state == ST_COPY) begin
                    sub <= sub + 1'b1;
                    if (sub == 2'd3)
                        idx <= idx + 1'b1;
                end
            end
        end
    end
endmodule

// File: rtl/sprite_line_eval_chk.sv
module sprite_line_eval_chk (
    input logic                    clk,
    input logic                    rst_n,
    input logic                    start,
    input logic                    frame_start,
    input logic                    sec_we,
    input logic [7:0]              sec_wdata,
    input logic                    done,
    input logic                    overflow,
    input spr_eval_pkg::eval_st_t  st
);
    import spr_eval_pkg::*;

    assert_reset_quiet_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(rst_n) |-> (!done && !overflow && !sec_we));

    assert_clear_fill_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (st == ST_CLEAR) |-> (sec_we && sec_wdata == 8'hFF));

    assert_ovf_sticky_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (overflow && !frame_start) |=> overflow);

    assert_ovf_clear_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (frame_start && st == ST_DONE) |=> !overflow);

    assert_done_quiet_R8: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> !sec_we);

    assert_start_drops_done_R1: assert property (@(posedge clk) disable iff (!rst_n)
        (done && start) |=> !done);
endmodule

bind sprite_line_eval sprite_line_eval_chk u_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .start       (start),
    .frame_start (frame_start),
    .sec_we      (sec_we),
    .sec_wdata   (sec_wdata),
    .done        (done),
    .overflow    (overflow),
    .st          (state)
);

// File: tb/test_sprite_line_eval.sv
module test_sprite_line_eval;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       start = 1'b0;
    logic       frame_start = 1'b0;
    logic [7:0] line = '0;
    logic       tall = 1'b0;
    logic [7:0] oam_addr;
    logic [7:0] oam_data;
    logic       sec_we;
    logic [4:0] sec_addr;
    logic [7:0] sec_wdata;
    logic       done;
    logic       overflow;

    logic [7:0]  oam [256];
    logic [13:0] exp_q [$];   // {is_clear, addr[4:0], data[7:0]}
    int checks = 0;
    int errors = 0;
    int cyc = 0;
    bit ovf_model = 1'b0;

    always #2 clk = ~clk;
    always @(posedge clk) cyc <= cyc + 1;

    assign oam_data = oam[oam_addr];

    sprite_line_eval i_sprite_line_eval (
        .clk(clk), .rst_n(rst_n), .start(start), .frame_start(frame_start),
        .line(line), .tall(tall), .oam_addr(oam_addr), .oam_data(oam_data),
        .sec_we(sec_we), .sec_addr(sec_addr), .sec_wdata(sec_wdata),
        .done(done), .overflow(overflow)
    );

    task automatic check(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Monitor: compare every buffer write against the scoreboard
    always @(negedge clk) begin
        if (rst_n && sec_we) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "R8 unexpected write", {sec_addr, sec_wdata}, 0);
            end else begin
                logic [13:0] e;
                e = exp_q.pop_front();
                check({sec_addr, sec_wdata} == e[12:0],
                      e[13] ? "R2 clear write" : "R5 R9 copy write",
                      {sec_addr, sec_wdata}, e[12:0]);
            end
        end
    end

    task automatic fill_far();
        for (int i = 0; i < 64; i++) begin
            oam[i*4]   = 8'hF0;
            oam[i*4+1] = 8'(i);
            oam[i*4+2] = 8'(i) ^ 8'hA5;
            oam[i*4+3] = 8'(i * 3);
        end
    endtask

    // Driver: build expected writes (R3 R4 R5) and run one evaluation
    task automatic run_eval(input logic [7:0] ln, input logic tl,
                            input int fs_at, input int poke_at);
        int n = 0;
        for (int a = 0; a < 32; a++) exp_q.push_back({1'b1, 5'(a), 8'hFF});
        for (int i = 0; i < 64; i++) begin
            logic [7:0] d;
            d = ln - oam[i*4];
            if (d < (tl ? 8'd16 : 8'd8)) begin
                if (n < 8)
                    for (int b = 0; b < 4; b++)
                        exp_q.push_back({1'b0, 3'(n), 2'(b), oam[i*4+b]});
                n++;
            end
        end
        if (n > 8) ovf_model = 1'b1;
        line = ln;
        tall = tl;
        start = 1'b1;
        @(negedge clk);
        start = 1'b0;
        check(done == 1'b0, "R1 done drops", done, 0);
        if (fs_at > 0) begin
            repeat (fs_at - 1) @(negedge clk);
            frame_start = 1'b1;
            @(negedge clk);
            frame_start = 1'b0;
        end
        if (poke_at > 0) begin
            repeat (poke_at - 1) @(negedge clk);
            start = 1'b1;
            @(negedge clk);
            start = 1'b0;
        end
        while (!done) @(negedge clk);
        repeat (4) @(negedge clk);
        check(done == 1'b1, "R8 done held", done, 1);
        check(exp_q.size() == 0, "R5 all writes seen", exp_q.size(), 0);
        check(overflow == ovf_model, "R6 overflow", overflow, ovf_model);
    endtask

    task automatic clear_ovf();
        frame_start = 1'b1;
        @(negedge clk);
        frame_start = 1'b0;
        ovf_model = 1'b0;
        check(overflow == 1'b0, "R7 frame_start clears", overflow, 0);
    endtask

    initial begin
        while (cyc < 100000) @(posedge clk);
        errors++;
        $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end

    initial begin
        fill_far();
        repeat (3) @(negedge clk);
        check(!done && !overflow && !sec_we, "R10 reset state",
              {done, overflow, sec_we}, 0);
        rst_n = 1'b1;
        @(negedge clk);
        check(!done && !overflow && !sec_we, "R10 after release",
              {done, overflow, sec_we}, 0);

        // R3 R4: short mode, boundary diffs 0, 5, 8, 255
        oam[3*4] = 8'd45; oam[10*4] = 8'd50; oam[20*4] = 8'd42; oam[30*4] = 8'd51;
        run_eval(8'd50, 1'b0, 0, 0);
        // R4: tall mode admits diff 8 and 15, not 16
        oam[40*4] = 8'd35; oam[41*4] = 8'd34;
        run_eval(8'd50, 1'b1, 0, 0);
        // R8: start during evaluation is ignored
        run_eval(8'd50, 1'b0, 0, 20);

        // R5 R6 R3: twelve matches, lowest eight kept
        fill_far();
        for (int i = 5; i < 17; i++) oam[i*4] = 8'd100;
        run_eval(8'd103, 1'b0, 0, 0);
        clear_ovf();

        // R6 boundary: exactly eight matches
        fill_far();
        for (int i = 0; i < 8; i++) oam[i*4] = 8'd200;
        run_eval(8'd207, 1'b0, 0, 0);

        // R7: frame_start in the same cycle as the ninth match (cycle 65)
        oam[8*4] = 8'd200;
        run_eval(8'd207, 1'b0, 65, 0);
        check(overflow == 1'b1, "R7 set wins", overflow, 1);
        clear_ovf();

        $display("Simulation finished: %0d checks, %0d errors", checks, errors);
        $finish;
    end
endmodule